// File: doc/BRIEF.md
# USB Host Controller Frame Timer and Register Block

This block is the timing core of a full-speed USB host controller. It holds the operational registers that software programs through a small I/O register bus, and it times the 1 ms frame. The registers are command, status, interrupt enable, frame number, frame list base and start-of-frame adjust. Accesses are 16 bits wide, except the frame list base, which may also be written with one 32-bit access.

While the controller runs, the block counts full-speed bit-time ticks. At the end of each frame it issues a one-cycle start-of-frame strobe and advances an 11-bit frame number. From the base register and the low ten bits of the frame number, it forms the memory address of the current 32-bit entry in a 1024-entry frame list. The schedule walker sets the status bits through event inputs, and an interrupt request is raised from those bits as the enables allow.

Software stops the controller by clearing the run bit. The current frame still completes, and only then is the halt reported. A host-reset command returns every register to its default value.

Top module: `hc_frame_timer`

## Requirements
- R1: After reset the registers read as follows: command 0x0000, status 0x0020 (halted), interrupt enable 0x0000, frame number 0x0000, frame list base 0x00000000 and start-of-frame adjust 0x0040. `halted_o` is 1 and `irq_o` is 0.
- R2: The registers sit at these byte offsets: command 0, status 2, interrupt enable 4, frame number 6, frame list base 8 (upper half also at 10) and start-of-frame adjust 12.
  - Command bits 0, 1, 2, 3, 4, 6 and 7 are run, host reset, global reset, global suspend, force resume, configure flag and 64-byte max packet. Bit 5 reads 0.
  - The interrupt enable register keeps 4 bits and the adjust register keeps 7 bits.
- R3: A frame lasts 12000 + (adjust − 64) bit ticks. `sof_strobe_o` is high for exactly one clock cycle at the end of each frame.
- R4: The frame counter advances only in cycles where `bit_tick_i` is high.
- R5: Each strobe advances the frame number by one, modulo 2048. A frame-number write takes effect only while halted and is ignored while running.
- R6: `fl_addr_o` is {base[31:12], frame number[9:0], 2'b00}. The base ignores writes to its bits 11:0.
  - A 32-bit write at offset 8 loads the whole base.
  - A 16-bit write at offset 8 loads bits 15:12 from data bits 15:12.
  - A 16-bit write at offset 10 loads bits 31:16.
- R7: Clearing the run bit lets the current frame complete. Halted (status bit 5, `halted_o`) is then set in the same cycle as that frame's strobe, and no further strobe follows. Setting the run bit clears halted one cycle after the write.
- R8: Status bits 0 to 4 are set by the events IOC, error, resume, host error and process error respectively.
  - They are cleared by writing 1, and writing 0 has no effect.
  - An event in the same cycle as a clear wins.
  - Bit 5 cannot be written.
- R9: `irq_o` is high when any of these holds:
  - the IOC bit is set while enable bit 2 (IOC) or bit 3 (short packet) is set;
  - the error bit is set while enable bit 0 (timeout/CRC) is set;
  - the resume bit is set while enable bit 1 is set;
  - the host-error or process-error bit is set (these two cannot be masked).
- R10: Writing 1 to command bit 1 restores every register to its R1 value within two clock cycles. The bit then reads 0 and the controller is halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when 1, read when 0 |
| bus_wide_i | input | 1 | 32-bit access when 1, 16-bit when 0 |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| bit_tick_i | input | 1 | One full-speed bit time elapsed |
| ev_ioc_i | input | 1 | Completion with interrupt request |
| ev_err_i | input | 1 | Transaction error |
| ev_resume_i | input | 1 | Resume signalling seen |
| ev_host_err_i | input | 1 | System bus error |
| ev_proc_err_i | input | 1 | Schedule processing error |
| sof_strobe_o | output | 1 | One-cycle frame boundary pulse |
| frnum_o | output | 11 | Current frame number |
| fl_addr_o | output | 32 | Address of the current frame-list entry |
| halted_o | output | 1 | Controller halted |
| irq_o | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle:
- the strobe is a single-cycle pulse;
- the frame number steps by exactly one with each strobe;
- a halted controller stays silent;
- the counter holds between bit ticks;
- an event always leaves its status bit set;
- host reset clears itself;
- the interrupt stays low when nothing unmaskable is pending and the enables are off.

Only the directed scenarios can show the rest: the exact frame length for each adjust value and tick rate, the completion of the last frame before the halt, the 2047-to-0 wrap, the frame-list address and the split base writes, and each interrupt gating case.

// File: rtl/hcft_pkg.sv
`timescale 1ns/1ps
package hcft_pkg;
  localparam int BUS_W = 32;

  localparam int OFS_CMD     = 0;
  localparam int OFS_STS     = 2;
  localparam int OFS_IEN     = 4;
  localparam int OFS_FRNUM   = 6;
  localparam int OFS_BASE    = 8;
  localparam int OFS_BASE_HI = 10;
  localparam int OFS_SOF     = 12;

  localparam int CMD_RUN    = 0;
  localparam int CMD_HRESET = 1;
  localparam int CMD_GRESET = 2;
  localparam int CMD_GSUSP  = 3;
  localparam int CMD_FRES   = 4;
  localparam int CMD_CFG    = 6;
  localparam int CMD_MAX64  = 7;
  localparam logic [7:0] CMD_MASK = 8'hDF;

  // bit 0 = ioc ... bit 4 = proc_err
  typedef struct packed {
    logic proc_err;
    logic host_err;
    logic resume;
    logic err;
    logic ioc;
  } sts_t;

  // bit 0 = timeout/crc ... bit 3 = short packet
  typedef struct packed {
    logic short_pkt;
    logic ioc;
    logic resume;
    logic timeout;
  } ien_t;
endpackage

// File: rtl/hcft_frame_timer.sv
`timescale 1ns/1ps
module hcft_frame_timer #(
  parameter int FRAME_BITS  = 12000,
  parameter int SOF_W       = 7,
  parameter int SOF_DEFAULT = 64,
  parameter int FN_W        = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             bit_tick_i,
  input  logic [SOF_W-1:0] sof_adj_i,
  input  logic             fn_wr_i,
  input  logic [FN_W-1:0]  fn_wdata_i,
  output logic             halted_o,
  output logic             sof_strobe_o,
  output logic [FN_W-1:0]  frnum_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + (1 << SOF_W));

  logic [CNT_W-1:0] cnt_q, last_cnt;
  logic [FN_W-1:0]  frnum_q;
  logic             halted_q, strobe_q;

  assign last_cnt = CNT_W'(FRAME_BITS - SOF_DEFAULT - 1)
                  + {{(CNT_W-SOF_W){1'b0}}, sof_adj_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      frnum_q  <= '0;
      halted_q <= 1'b1;
      strobe_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q    <= '0;
      frnum_q  <= '0;
      halted_q <= 1'b1;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (halted_q) begin
        cnt_q <= '0;
        if (fn_wr_i) frnum_q <= fn_wdata_i;
        if (run_i)   halted_q <= 1'b0;
      end else if (bit_tick_i) begin
        // >= tolerates the adjust shrinking mid-frame
        if (cnt_q >= last_cnt) begin
          cnt_q    <= '0;
          strobe_q <= 1'b1;
          frnum_q  <= frnum_q + FN_W'(1);
          if (!run_i) halted_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign halted_o     = halted_q;
  assign sof_strobe_o = strobe_q;
  assign frnum_o      = frnum_q;

  // R3
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |=> !strobe_q);
  // R5
  frnum_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |-> frnum_q == FN_W'($past(frnum_q) + FN_W'(1)));
  // R7
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_q && $past(halted_q)) |-> !strobe_q);
  // R4
  tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_q && !bit_tick_i && !clr_i) |=> $stable(cnt_q) && $stable(frnum_q));
endmodule

// File: rtl/hcft_irq.sv
`timescale 1ns/1ps
module hcft_irq
  import hcft_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  sts_t sts_i,
  input  ien_t ien_i,
  output logic irq_o
);
  logic ioc_hit, err_hit, res_hit, fatal_hit;

  assign ioc_hit   = sts_i.ioc & (ien_i.ioc | ien_i.short_pkt);
  assign err_hit   = sts_i.err & ien_i.timeout;
  assign res_hit   = sts_i.resume & ien_i.resume;
  // system and schedule faults have no enable
  assign fatal_hit = sts_i.host_err | sts_i.proc_err;
  assign irq_o     = ioc_hit | err_hit | res_hit | fatal_hit;

  // R9
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_i == '0 && !sts_i.host_err && !sts_i.proc_err) |-> !irq_o);
endmodule

// File: rtl/hcft_regs.sv
`timescale 1ns/1ps
module hcft_regs
  import hcft_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SOF_W       = 7,
  parameter int SOF_DEFAULT = 64,
  parameter int FN_W        = 11,
  parameter int BASE_W      = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic              bus_wide_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  sts_t              ev_i,
  input  logic              halted_i,
  input  logic [FN_W-1:0]   frnum_i,
  output logic              run_o,
  output logic              clr_o,
  output logic              fn_wr_o,
  output logic [FN_W-1:0]   fn_wdata_o,
  output logic [SOF_W-1:0]  sof_adj_o,
  output logic [BASE_W-1:0] base_o,
  output sts_t              sts_o,
  output ien_t              ien_o
);
  localparam int LOW_SHIFT = BUS_W - BASE_W;
  localparam int LO_BITS   = 16 - LOW_SHIFT;

  logic [7:0]        cmd_q;
  sts_t              sts_q;
  ien_t              ien_q;
  logic [BASE_W-1:0] base_q;
  logic [SOF_W-1:0]  sof_q;

  logic wr, wr_cmd, wr_sts, wr_ien, wr_fn, wr_base_lo, wr_base_hi, wr_sof;
  logic [4:0] w1c;

  assign wr         = bus_en_i & bus_we_i;
  assign wr_cmd     = wr && bus_addr_i == ADDR_W'(OFS_CMD);
  assign wr_sts     = wr && bus_addr_i == ADDR_W'(OFS_STS);
  assign wr_ien     = wr && bus_addr_i == ADDR_W'(OFS_IEN);
  assign wr_fn      = wr && bus_addr_i == ADDR_W'(OFS_FRNUM);
  assign wr_base_lo = wr && bus_addr_i == ADDR_W'(OFS_BASE);
  assign wr_base_hi = wr && !bus_wide_i && bus_addr_i == ADDR_W'(OFS_BASE_HI);
  assign wr_sof     = wr && bus_addr_i == ADDR_W'(OFS_SOF);
  assign w1c        = wr_sts ? bus_wdata_i[4:0] : 5'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      sts_q  <= '0;
      ien_q  <= '0;
      base_q <= '0;
      sof_q  <= SOF_W'(SOF_DEFAULT);
    end else if (cmd_q[CMD_HRESET]) begin
      cmd_q  <= '0;
      sts_q  <= '0;
      ien_q  <= '0;
      base_q <= '0;
      sof_q  <= SOF_W'(SOF_DEFAULT);
    end else begin
      // events win over a simultaneous clear
      sts_q <= sts_t'((sts_q & ~w1c) | ev_i);
      if (wr_cmd) cmd_q <= bus_wdata_i[7:0] & CMD_MASK;
      if (wr_ien) ien_q <= ien_t'(bus_wdata_i[3:0]);
      if (wr_sof) sof_q <= bus_wdata_i[SOF_W-1:0];
      if (wr_base_lo) begin
        if (bus_wide_i) base_q <= bus_wdata_i[BUS_W-1:LOW_SHIFT];
        else            base_q[LO_BITS-1:0] <= bus_wdata_i[15:LOW_SHIFT];
      end
      if (wr_base_hi) base_q[BASE_W-1:LO_BITS] <= bus_wdata_i[15:0];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(OFS_CMD))
      bus_rdata_o = {{(BUS_W-8){1'b0}}, cmd_q};
    else if (bus_addr_i == ADDR_W'(OFS_STS))
      bus_rdata_o = {{(BUS_W-6){1'b0}}, halted_i, sts_q};
    else if (bus_addr_i == ADDR_W'(OFS_IEN))
      bus_rdata_o = {{(BUS_W-4){1'b0}}, ien_q};
    else if (bus_addr_i == ADDR_W'(OFS_FRNUM))
      bus_rdata_o = {{(BUS_W-FN_W){1'b0}}, frnum_i};
    else if (bus_addr_i == ADDR_W'(OFS_BASE))
      bus_rdata_o = {base_q, {LOW_SHIFT{1'b0}}};
    else if (bus_addr_i == ADDR_W'(OFS_BASE_HI))
      bus_rdata_o = {16'b0, base_q[BASE_W-1:LO_BITS]};
    else if (bus_addr_i == ADDR_W'(OFS_SOF))
      bus_rdata_o = {{(BUS_W-SOF_W){1'b0}}, sof_q};
  end

  assign run_o      = cmd_q[CMD_RUN];
  assign clr_o      = cmd_q[CMD_HRESET];
  assign fn_wr_o    = wr_fn;
  assign fn_wdata_o = bus_wdata_i[FN_W-1:0];
  assign sof_adj_o  = sof_q;
  assign base_o     = base_q;
  assign sts_o      = sts_q;
  assign ien_o      = ien_q;

  // R10
  hreset_selfclear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q[CMD_HRESET] |=> !cmd_q[CMD_HRESET] && sof_q == SOF_W'(SOF_DEFAULT) && ien_q == '0);
  // R8
  ioc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i.ioc && !cmd_q[CMD_HRESET]) |=> sts_q.ioc);
endmodule

// File: rtl/hc_frame_timer.sv
`timescale 1ns/1ps
module hc_frame_timer
  import hcft_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int FRAME_BITS  = 12000,
  parameter int SOF_W       = 7,
  parameter int SOF_DEFAULT = 64,
  parameter int FN_W        = 11,
  parameter int FL_ENTRIES  = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic              bus_wide_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              bit_tick_i,
  input  logic              ev_ioc_i,
  input  logic              ev_err_i,
  input  logic              ev_resume_i,
  input  logic              ev_host_err_i,
  input  logic              ev_proc_err_i,
  output logic              sof_strobe_o,
  output logic [FN_W-1:0]   frnum_o,
  output logic [31:0]       fl_addr_o,
  output logic              halted_o,
  output logic              irq_o
);
  localparam int IDX_W  = $clog2(FL_ENTRIES);
  localparam int BASE_W = BUS_W - IDX_W - 2;

  sts_t              ev, sts;
  ien_t              ien;
  logic              run, clr, fn_wr, halted;
  logic [FN_W-1:0]   fn_wdata, frnum;
  logic [SOF_W-1:0]  sof_adj;
  logic [BASE_W-1:0] base;

  assign ev = {ev_proc_err_i, ev_host_err_i, ev_resume_i, ev_err_i, ev_ioc_i};

  hcft_regs #(
    .ADDR_W(ADDR_W), .SOF_W(SOF_W), .SOF_DEFAULT(SOF_DEFAULT),
    .FN_W(FN_W), .BASE_W(BASE_W)
  ) u_regs (
    .clk_i, .rst_ni, .bus_en_i, .bus_we_i, .bus_wide_i, .bus_addr_i,
    .bus_wdata_i, .bus_rdata_o,
    .ev_i(ev), .halted_i(halted), .frnum_i(frnum),
    .run_o(run), .clr_o(clr), .fn_wr_o(fn_wr), .fn_wdata_o(fn_wdata),
    .sof_adj_o(sof_adj), .base_o(base), .sts_o(sts), .ien_o(ien)
  );

  hcft_frame_timer #(
    .FRAME_BITS(FRAME_BITS), .SOF_W(SOF_W), .SOF_DEFAULT(SOF_DEFAULT), .FN_W(FN_W)
  ) u_timer (
    .clk_i, .rst_ni, .clr_i(clr), .run_i(run), .bit_tick_i,
    .sof_adj_i(sof_adj), .fn_wr_i(fn_wr), .fn_wdata_i(fn_wdata),
    .halted_o(halted), .sof_strobe_o, .frnum_o(frnum)
  );

  hcft_irq u_irq (
    .clk_i, .rst_ni, .sts_i(sts), .ien_i(ien), .irq_o
  );

  assign frnum_o   = frnum;
  assign halted_o  = halted;
  assign fl_addr_o = {base, frnum[IDX_W-1:0], 2'b00};
endmodule

// File: tb/tb_hc_frame_timer.sv
`timescale 1ns/1ps
module tb_hc_frame_timer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        en = 0, we = 0, wide = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata, fl_addr;
  logic        tick, ioc = 0, err = 0, res = 0, herr = 0, perr = 0;
  logic        sof, halted, irq;
  logic [10:0] frnum;
  logic        half_rate = 0;
  logic [31:0] cyc = 0;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;
  assign tick = half_rate ? cyc[0] : 1'b1;

  hc_frame_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(en), .bus_we_i(we), .bus_wide_i(wide),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bit_tick_i(tick),
    .ev_ioc_i(ioc), .ev_err_i(err), .ev_resume_i(res), .ev_host_err_i(herr),
    .ev_proc_err_i(perr), .sof_strobe_o(sof), .frnum_o(frnum), .fl_addr_o(fl_addr),
    .halted_o(halted), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic w = 1'b0);
    @(negedge clk);
    en = 1; we = 1; addr = a; wdata = d; wide = w;
    @(negedge clk);
    en = 0; we = 0; wide = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_sof(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sof && n < 30000);
    if (!sof) chk("R3 strobe timeout", 0, 1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v);  chk("R1 cmd", v, 32'h0);
    rd(2, v);  chk("R1 sts", v, 32'h20);
    rd(4, v);  chk("R1 ien", v, 32'h0);
    rd(6, v);  chk("R1 frnum", v, 32'h0);
    rd(8, v);  chk("R1 base", v, 32'h0);
    rd(12, v); chk("R1 sof", v, 32'h40);
    chk("R1 halted_o", halted, 1);
    chk("R1 irq_o", irq, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(0, 32'h00FC); rd(0, v); chk("R2 cmd bits, bit5 reads 0", v, 32'hDC);
    wr(0, 32'h0);
    wr(4, 32'hFFFF); rd(4, v); chk("R2 ien width", v, 32'hF);
    wr(4, 32'h0);
    wr(12, 32'hFFFF); rd(12, v); chk("R2 sof width", v, 32'h7F);
    wr(12, 32'h40);
    wr(8, 32'hABCDEFFF, 1'b1); rd(8, v); chk("R6 wide base, low 12 ignored", v, 32'hABCDE000);
    wr(10, 32'h1234); rd(8, v); chk("R6 base upper half", v, 32'h1234E000);
    rd(10, v); chk("R6 base read at 10", v, 32'h1234);
    wr(8, 32'hF000); rd(8, v); chk("R6 base lower half", v, 32'h1234F000);
    wr(6, 32'd1023); rd(6, v); chk("R5 frnum write while halted", v, 32'd1023);
    chk("R6 fl_addr index 1023", fl_addr, 32'h1234FFFC);
  endtask

  task automatic t_run();
    int n;
    logic [31:0] v;
    wr(0, 32'h1);
    wait_sof(n);
    chk("R5 frnum after strobe", frnum, 11'd1024);
    chk("R6 fl_addr wraps index", fl_addr, 32'h1234F000);
    @(negedge clk);
    chk("R3 strobe one cycle", sof, 0);
    wait_sof(n);
    chk("R3 default frame length", n + 1, 12000);
    chk("R5 frnum step", frnum, 11'd1025);
    wr(6, 32'd5); rd(6, v);
    chk("R5 frnum write ignored while running", v, 32'd1025);
  endtask

  task automatic t_sof_adjust();
    int n;
    wait_sof(n);
    wr(12, 32'd127);
    wait_sof(n);
    chk("R3 frame length adjust 127", n + 2, 12063);
    wr(12, 32'd0);
    wait_sof(n);
    chk("R3 frame length adjust 0", n + 2, 11936);
    wr(12, 32'd64);
  endtask

  task automatic t_halt();
    int n, seen;
    logic [10:0] f0;
    logic [31:0] v;
    wait_sof(n);
    f0 = frnum;
    wr(0, 32'h0);
    chk("R7 still running after stop request", halted, 0);
    wait_sof(n);
    chk("R7 last frame completes", n + 2, 12000);
    chk("R7 halted with last strobe", halted, 1);
    chk("R7 frnum advanced by last frame", frnum, f0 + 11'd1);
    rd(2, v); chk("R7 status halted bit", v, 32'h20);
    seen = 0;
    repeat (300) begin
      @(negedge clk);
      if (sof) seen++;
    end
    chk("R7 no strobe when halted", seen, 0);
  endtask

  task automatic pulse(input logic [4:0] m);
    @(negedge clk);
    {perr, herr, res, err, ioc} = m;
    @(negedge clk);
    {perr, herr, res, err, ioc} = '0;
  endtask

  task automatic t_irq();
    logic [31:0] v;
    pulse(5'b00001);
    rd(2, v); chk("R8 ioc event sets bit 0", v, 32'h21);
    chk("R9 ioc masked", irq, 0);
    wr(4, 32'h8); @(negedge clk); chk("R9 short-packet enable covers ioc", irq, 1);
    wr(4, 32'h4); @(negedge clk); chk("R9 ioc enable", irq, 1);
    wr(2, 32'h0); rd(2, v); chk("R8 write 0 keeps bits", v, 32'h21);
    wr(2, 32'h21); rd(2, v); chk("R8 w1c clears, halted not writable", v, 32'h20);
    chk("R9 irq drops after clear", irq, 0);
    wr(4, 32'h1); pulse(5'b00010); @(negedge clk);
    chk("R9 error with timeout enable", irq, 1);
    wr(2, 32'h2); @(negedge clk); chk("R8 error cleared", irq, 0);
    wr(4, 32'h0); pulse(5'b00100); @(negedge clk);
    chk("R9 resume masked", irq, 0);
    wr(4, 32'h2); @(negedge clk); chk("R9 resume enabled", irq, 1);
    wr(2, 32'h4); wr(4, 32'h0);
    pulse(5'b01000); @(negedge clk); chk("R9 host error unmaskable", irq, 1);
    wr(2, 32'h8); @(negedge clk); chk("R8 host error cleared", irq, 0);
    pulse(5'b10000); @(negedge clk); chk("R9 process error unmaskable", irq, 1);
    wr(2, 32'h10);
    @(negedge clk);
    en = 1; we = 1; addr = 2; wdata = 32'h1; ioc = 1;
    @(negedge clk);
    en = 0; we = 0; ioc = 0;
    rd(2, v); chk("R8 event wins over clear", v, 32'h21);
    wr(2, 32'h1F); rd(2, v); chk("R8 all cleared", v, 32'h20);
  endtask

  task automatic t_wrap();
    int n;
    logic [31:0] v;
    wr(6, 32'd2047); rd(6, v); chk("R5 frnum 2047 loaded", v, 32'd2047);
    half_rate = 1;
    wr(0, 32'h1);
    @(negedge clk);
    chk("R7 run clears halted", halted, 0);
    wait_sof(n);
    chk("R5 frnum wraps to 0", frnum, 11'd0);
    chk("R6 fl_addr at frame 0", fl_addr, 32'h1234F000);
    wait_sof(n);
    chk("R4 half tick rate doubles frame", n, 24000);
    half_rate = 0;
  endtask

  task automatic t_hreset();
    logic [31:0] v;
    wr(4, 32'hF); wr(12, 32'd9);
    pulse(5'b00001);
    repeat (20) @(negedge clk);
    wr(0, 32'h3);
    @(negedge clk);
    rd(0, v);  chk("R10 cmd self-clears", v, 32'h0);
    rd(2, v);  chk("R10 sts default", v, 32'h20);
    rd(4, v);  chk("R10 ien default", v, 32'h0);
    rd(6, v);  chk("R10 frnum default", v, 32'h0);
    rd(8, v);  chk("R10 base default", v, 32'h0);
    rd(12, v); chk("R10 sof default", v, 32'h40);
    chk("R10 halted", halted, 1);
    chk("R10 irq low", irq, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R1-all actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_run();
    t_sof_adjust();
    t_halt();
    t_irq();
    t_wrap();
    t_hreset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule